// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets a small CPU rewrite its own program flash. The CPU first writes a five-bit control register that arms one command, then issues a store strobe or a load strobe. Arming opens a short timed window. A store strobe inside that window does one of three things. It can put a 16-bit data word into a 32-word temporary page buffer. It can start a page erase. It can start a page write that copies the buffer into flash. A load strobe inside a shorter window returns fuse or lock bits in place of flash data.

Erase and write go to a simple flash port as a one-cycle request that carries the operation code and the page number. The port answers on a busy line, and an operation ends when busy falls. For the whole operation the block holds the CPU halted. The armed bits stay visible in the register until the operation ends, and they clear by themselves when it ends or when the window runs out unused. The flash port reads the page buffer through its own read index.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset the control register reads 0, `cpu_halt` and `fl_req` are low, and every buffer word reads 16'hFFFF.
- R2: Writing the control register with bit 0 (enable) set arms a command for four cycles. With no matching strobe, the register still reads armed after the first three clock edges that follow the write, and reads 0 after the fourth.
- R3: With only the enable armed, a store strobe on any of those four edges writes `st_data` into buffer word `zptr[5:1]`. `zptr[0]` has no effect. The register then reads 0.
- R4: With bit 1 (erase) armed, a store strobe causes `fl_req` to go high for exactly one cycle on the cycle after the strobe edge, with `fl_op` = 0 and `fl_page` = `zptr[15:6]`.
- R5: With bit 2 (write) armed, a store strobe issues the same request with `fl_op` = 1.
- R6: From the cycle after the strobe edge until the first edge that samples busy low after having sampled it high, `cpu_halt` is high and the register keeps the enable bit and the operation bit. After that edge both `cpu_halt` and the register read 0.
- R7: A register write with bit 4 set resets every buffer word to 16'hFFFF. Bit 4 always reads 0.
- R8: With bit 3 (fuse/lock read) armed, a load strobe on one of the first three edges after the write raises `ld_special` during the strobe cycle. `ld_data` is then `lock_bits` when `zptr[0]` is 1 and `fuse_bits` when it is 0. A load strobe on the fourth edge is not honoured.
- R9: When several command bits are written together with the enable, only one is kept. Erase wins over write, write over fuse/lock read, and fuse/lock read over buffer fill. The register then shows only the enable bit and the winning bit.
- R10: Register writes, including the buffer-clear bit, have no effect while a flash operation is in progress.
- R11: A store strobe after the window has expired leaves the buffer unchanged.
- R12: A register write with bit 0 clear disarms any pending command, so a store strobe right after it leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data: bit0 enable, bit1 erase, bit2 write, bit3 fuse/lock read, bit4 clear buffer |
| ctl_rdata | output | 5 | Control register readback |
| st_strobe | input | 1 | Store strobe from the CPU |
| ld_strobe | input | 1 | Load strobe from the CPU |
| zptr | input | 16 | Address pointer: [15:6] page, [5:1] word, [0] fuse/lock select |
| st_data | input | 16 | Data word for a buffer fill |
| fuse_bits | input | 8 | Fuse value from the fuse store |
| lock_bits | input | 8 | Lock value from the fuse store |
| ld_special | output | 1 | High when the current load returns fuse/lock data |
| ld_data | output | 8 | Fuse or lock value, 0 when `ld_special` is low |
| cpu_halt | output | 1 | Stall request to the CPU |
| fl_req | output | 1 | One-cycle flash operation request |
| fl_op | output | 1 | Operation code: 0 erase, 1 write |
| fl_page | output | 10 | Page number of the request |
| fl_busy | input | 1 | Flash busy; its falling edge ends the operation |
| buf_rd_idx | input | 5 | Buffer read index for the flash port |
| buf_rd_data | output | 16 | Buffer word at `buf_rd_idx` |

## Verification
The bench drives every input just after a falling clock edge and samples at the next falling edge. Register readback, buffer contents, `fl_req` and `cpu_halt` are therefore checked one rising edge after the stimulus, and the window test samples after each of the four edges that follow the arming write. `ld_special` and `ld_data` are combinational, so they are checked 2 ns after the load strobe is applied, within the same cycle. Operation completion is checked at the falling edge after the one where busy was lowered, which is the first rising edge that sees busy low after seeing it high.

// File: rtl/fsp_pkg.sv
`timescale 1ns/100ps
package fsp_pkg;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_ERS = 1;
  localparam int unsigned BIT_WRT = 2;
  localparam int unsigned BIT_RDF = 3;
  localparam int unsigned BIT_CLR = 4;
  localparam int unsigned CTL_W   = 5;

  localparam logic OP_ERASE = 1'b0;
  localparam logic OP_WRITE = 1'b1;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_FILL, CMD_ERASE, CMD_WRITE, CMD_FUSE
  } cmd_e;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ISSUE, SEQ_RUN} seq_e;

  // Priority pick among the command bits written with the enable.
  function automatic cmd_e pick_cmd(input logic [CTL_W-1:0] v);
    if (!v[BIT_EN])      return CMD_NONE;
    else if (v[BIT_ERS]) return CMD_ERASE;
    else if (v[BIT_WRT]) return CMD_WRITE;
    else if (v[BIT_RDF]) return CMD_FUSE;
    else                 return CMD_FILL;
  endfunction

  // Register image of a held command.
  function automatic logic [CTL_W-1:0] cmd_bits(input cmd_e c);
    logic [CTL_W-1:0] b;
    b = '0;
    b[BIT_EN]  = (c != CMD_NONE);
    b[BIT_ERS] = (c == CMD_ERASE);
    b[BIT_WRT] = (c == CMD_WRITE);
    b[BIT_RDF] = (c == CMD_FUSE);
    return b;
  endfunction
endpackage

// File: rtl/fsp_cmd_window.sv
`timescale 1ns/100ps
module fsp_cmd_window
  import fsp_pkg::*;
#(
  parameter int unsigned WIN    = 4,
  parameter int unsigned RD_WIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             st,
  input  logic             ld,
  input  logic             op_busy,
  input  logic             op_done,
  output logic [CTL_W-1:0] reg_bits,
  output logic             fire_fill,
  output logic             fire_erase,
  output logic             fire_write,
  output logic             fire_fuse,
  output logic             clr_buf
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] WIN_C    = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] RD_FLOOR = CNT_W'(WIN - RD_WIN);

  cmd_e             cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept_wr, armed, expire;
  cmd_e             picked;

  assign accept_wr = wr & ~op_busy;
  assign picked    = pick_cmd(wdata);
  assign armed     = (cnt_q != '0) & ~wr;
  assign clr_buf   = accept_wr & wdata[BIT_CLR];

  assign fire_fill  = armed & st & (cmd_q == CMD_FILL);
  assign fire_erase = armed & st & (cmd_q == CMD_ERASE);
  assign fire_write = armed & st & (cmd_q == CMD_WRITE);
  assign fire_fuse  = armed & ld & (cmd_q == CMD_FUSE) & (cnt_q > RD_FLOOR);
  assign expire     = armed & (cnt_q == CNT_W'(1));

  always_comb begin
    cmd_d = cmd_q;
    cnt_d = cnt_q;
    if (op_done) begin
      cmd_d = CMD_NONE;
      cnt_d = '0;
    end else if (accept_wr) begin
      cmd_d = picked;
      cnt_d = (picked == CMD_NONE) ? '0 : WIN_C;
    end else if (fire_fill || fire_fuse) begin
      cmd_d = CMD_NONE;
      cnt_d = '0;
    end else if (fire_erase || fire_write) begin
      cnt_d = '0;
    end else if (expire) begin
      cmd_d = CMD_NONE;
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_NONE;
      cnt_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      cnt_q <= cnt_d;
    end
  end

  assign reg_bits = cmd_bits(cmd_q);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIN_C);
  assert_expire_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && !wr && !st && !op_done) |=> (cmd_q == CMD_NONE));
  assert_single_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_fill, fire_erase, fire_write, fire_fuse}));
  assert_op_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !op_done) |=> $stable(cmd_q));
endmodule

// File: rtl/fsp_page_buffer.sv
`timescale 1ns/100ps
module fsp_page_buffer #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '1;
      else if (clr) word_q[g] <= '1;
      else if (hit) word_q[g] <= wdata;
    end
  end

  assign rdata = word_q[ridx];

  assert_clear_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (word_q[0] == '1 && word_q[DEPTH-1] == '1));
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr && widx == '0) |=> (word_q[0] == $past(wdata)));
endmodule

// File: rtl/fsp_flash_seq.sv
`timescale 1ns/100ps
module fsp_flash_seq
  import fsp_pkg::*;
#(
  parameter int unsigned PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_erase,
  input  logic              fire_write,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              fl_busy,
  output logic              fl_req,
  output logic              fl_op,
  output logic [PAGE_W-1:0] fl_page,
  output logic              op_busy,
  output logic              op_done
);
  seq_e state_q;
  logic busy_q;

  assign op_done = (state_q == SEQ_RUN) & busy_q & ~fl_busy;
  assign op_busy = (state_q != SEQ_IDLE);
  assign fl_req  = (state_q == SEQ_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      busy_q  <= 1'b0;
      fl_op   <= OP_ERASE;
      fl_page <= '0;
    end else begin
      busy_q <= fl_busy;
      case (state_q)
        SEQ_IDLE: if (fire_erase || fire_write) begin
          state_q <= SEQ_ISSUE;
          fl_op   <= fire_write ? OP_WRITE : OP_ERASE;
          fl_page <= page_in;
        end
        SEQ_ISSUE: state_q <= SEQ_RUN;
        SEQ_RUN:   if (op_done) state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> !fl_req);
  assert_req_follows_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_erase || fire_write) |=> (fl_req && fl_op == $past(fire_write)));
  assert_busy_keeps_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && fl_busy) |=> op_busy);
endmodule

// File: rtl/flash_selfprog_ctrl.sv
`timescale 1ns/100ps
module flash_selfprog_ctrl
  import fsp_pkg::*;
#(
  parameter int unsigned Z_W    = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned FB_W   = 8,
  parameter int unsigned WIN    = 4,
  parameter int unsigned RD_WIN = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_wr,
  input  logic [4:0]             ctl_wdata,
  output logic [4:0]             ctl_rdata,
  input  logic                   st_strobe,
  input  logic                   ld_strobe,
  input  logic [Z_W-1:0]         zptr,
  input  logic [DATA_W-1:0]      st_data,
  input  logic [FB_W-1:0]        fuse_bits,
  input  logic [FB_W-1:0]        lock_bits,
  output logic                   ld_special,
  output logic [FB_W-1:0]        ld_data,
  output logic                   cpu_halt,
  output logic                   fl_req,
  output logic                   fl_op,
  output logic [Z_W-IDX_W-2:0]   fl_page,
  input  logic                   fl_busy,
  input  logic [IDX_W-1:0]       buf_rd_idx,
  output logic [DATA_W-1:0]      buf_rd_data
);
  localparam int unsigned PAGE_W = Z_W - IDX_W - 1;

  function automatic logic [IDX_W-1:0] word_of(input logic [Z_W-1:0] z);
    return z[IDX_W:1];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [Z_W-1:0] z);
    return z[Z_W-1:IDX_W+1];
  endfunction

  logic fire_fill, fire_erase, fire_write, fire_fuse, clr_buf;
  logic op_busy, op_done;

  fsp_cmd_window #(.WIN(WIN), .RD_WIN(RD_WIN)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (ctl_wr),
    .wdata      (ctl_wdata),
    .st         (st_strobe),
    .ld         (ld_strobe),
    .op_busy    (op_busy),
    .op_done    (op_done),
    .reg_bits   (ctl_rdata),
    .fire_fill  (fire_fill),
    .fire_erase (fire_erase),
    .fire_write (fire_write),
    .fire_fuse  (fire_fuse),
    .clr_buf    (clr_buf)
  );

  fsp_page_buffer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fire_fill),
    .widx  (word_of(zptr)),
    .wdata (st_data),
    .clr   (clr_buf),
    .ridx  (buf_rd_idx),
    .rdata (buf_rd_data)
  );

  fsp_flash_seq #(.PAGE_W(PAGE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_erase (fire_erase),
    .fire_write (fire_write),
    .page_in    (page_of(zptr)),
    .fl_busy    (fl_busy),
    .fl_req     (fl_req),
    .fl_op      (fl_op),
    .fl_page    (fl_page),
    .op_busy    (op_busy),
    .op_done    (op_done)
  );

  assign cpu_halt   = op_busy;
  assign ld_special = fire_fuse;
  assign ld_data    = !fire_fuse ? '0 : (zptr[0] ? lock_bits : fuse_bits);

  assert_halt_keeps_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (ctl_rdata[BIT_EN] && (ctl_rdata[BIT_ERS] || ctl_rdata[BIT_WRT])));
  assert_halt_ends_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_halt) |-> (ctl_rdata == '0));
  assert_clr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[BIT_CLR]);
  assert_no_clear_in_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |=> $stable(buf_rd_data) || $changed(buf_rd_idx));
endmodule

// File: tb/flash_selfprog_ctrl_tb.sv
`timescale 1ns/100ps
module flash_selfprog_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [4:0]  ctl_wdata = '0;
  logic [4:0]  ctl_rdata;
  logic        st_strobe = 1'b0;
  logic        ld_strobe = 1'b0;
  logic [15:0] zptr = '0;
  logic [15:0] st_data = '0;
  logic [7:0]  fuse_bits = 8'h62;
  logic [7:0]  lock_bits = 8'hFC;
  logic        ld_special;
  logic [7:0]  ld_data;
  logic        cpu_halt, fl_req, fl_op;
  logic [9:0]  fl_page;
  logic        fl_busy = 1'b0;
  logic [4:0]  buf_rd_idx = '0;
  logic [15:0] buf_rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_buf [32];

  always #10 clk = ~clk;

  flash_selfprog_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .st_strobe(st_strobe), .ld_strobe(ld_strobe),
    .zptr(zptr), .st_data(st_data), .fuse_bits(fuse_bits), .lock_bits(lock_bits),
    .ld_special(ld_special), .ld_data(ld_data), .cpu_halt(cpu_halt),
    .fl_req(fl_req), .fl_op(fl_op), .fl_page(fl_page), .fl_busy(fl_busy),
    .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data)
  );

  function automatic logic [9:0] exp_page(input logic [15:0] z);
    return 10'(z / 64);
  endfunction
  function automatic int exp_word(input logic [15:0] z);
    return (int'(z) / 2) % 32;
  endfunction
  function automatic logic [4:0] exp_reg(input logic [4:0] w);
    if (w[0] == 1'b0) return 5'h00;
    if (w[1]) return 5'h03;
    if (w[2]) return 5'h05;
    if (w[3]) return 5'h09;
    return 5'h01;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic store(input logic [15:0] z, input logic [15:0] d);
    zptr = z; st_data = d; st_strobe = 1'b1;
    @(negedge clk);
    st_strobe = 1'b0;
  endtask

  task automatic check_buf(input string tag);
    for (int i = 0; i < 32; i++) begin
      buf_rd_idx = 5'(i);
      #0.1;
      check(tag, {16'h0, buf_rd_data}, {16'h0, exp_buf[i]});
    end
  endtask

  task automatic fill(input int k, input logic [15:0] z, input logic [15:0] d);
    wr_ctl(5'h01);
    idle(k);
    store(z, d);
    if (k <= 3) exp_buf[exp_word(z)] = d;
    check("R3/R11 reg after store", {27'h0, ctl_rdata}, 32'h0);
  endtask

  task automatic clear_buf();
    wr_ctl(5'h10);
    for (int i = 0; i < 32; i++) exp_buf[i] = 16'hFFFF;
    check("R7 clear bit reads 0", {27'h0, ctl_rdata}, 32'h0);
  endtask

  task automatic flash_op(input logic [4:0] ctl, input logic [15:0] z, input int n);
    logic [4:0] r;
    r = exp_reg(ctl);
    wr_ctl(ctl);
    store(z, 16'h1234);
    check("R4/R5 req", {31'h0, fl_req}, 32'h1);
    check("R4/R5 op", {31'h0, fl_op}, {31'h0, r[2]});
    check("R4 page", {22'h0, fl_page}, {22'h0, exp_page(z)});
    check("R6 halt on", {31'h0, cpu_halt}, 32'h1);
    fl_busy = 1'b1;
    idle(1);
    check("R4 req single", {31'h0, fl_req}, 32'h0);
    wr_ctl(5'h10);
    check("R10 write ignored", {27'h0, ctl_rdata}, {27'h0, r});
    for (int i = 0; i < n; i++) begin
      check("R6 halt held", {31'h0, cpu_halt}, 32'h1);
      check("R6 reg held", {27'h0, ctl_rdata}, {27'h0, r});
      idle(1);
    end
    fl_busy = 1'b0;
    idle(1);
    check("R6 halt off", {31'h0, cpu_halt}, 32'h0);
    check("R6 reg off", {27'h0, ctl_rdata}, 32'h0);
  endtask

  task automatic fuse_read(input int k, input logic z0);
    wr_ctl(5'h09);
    idle(k);
    zptr = {15'h0, z0}; ld_strobe = 1'b1;
    #2;
    check("R8 special", {31'h0, ld_special}, {31'h0, (k <= 2)});
    check("R8 data", {24'h0, ld_data},
          (k <= 2) ? {24'h0, (z0 ? lock_bits : fuse_bits)} : 32'h0);
    @(negedge clk);
    ld_strobe = 1'b0;
    check("R8 reg after", {27'h0, ctl_rdata}, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 32; i++) exp_buf[i] = 16'hFFFF;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 reg", {27'h0, ctl_rdata}, 32'h0);
    check("R1 halt", {31'h0, cpu_halt}, 32'h0);
    check("R1 req", {31'h0, fl_req}, 32'h0);
    check_buf("R1 buffer");

    // R2 window expiry
    wr_ctl(5'h01);
    for (int i = 1; i <= 4; i++) begin
      idle(1);
      check("R2 window", {27'h0, ctl_rdata}, (i < 4) ? 32'h1 : 32'h0);
    end

    // R3 last window edge, odd Z; R11 late strobe
    fill(3, 16'h0007, 16'hBEEF);
    fill(4, 16'h0009, 16'hDEAD);
    fill(0, 16'hFFFE, 16'h0101);
    check_buf("R3/R11 directed");

    // R12 disarm
    wr_ctl(5'h01);
    wr_ctl(5'h00);
    store(16'h0010, 16'h5555);
    check_buf("R12 disarmed");

    // R7 clear
    clear_buf();
    check_buf("R7 cleared");

    // random fills with occasional clears
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(0, 9) == 0) clear_buf();
      else fill($urandom_range(0, 5), 16'($urandom), 16'($urandom));
    end
    check_buf("R3/R7/R11 random");

    // R4, R5, R6, R10
    flash_op(5'h03, 16'hABCD, 5);
    check_buf("R10 buffer kept");
    flash_op(5'h05, 16'h0040, 3);
    flash_op(5'h05, 16'($urandom), $urandom_range(1, 8));
    flash_op(5'h0F, 16'($urandom), 2);
    flash_op(5'h07, 16'h7FC0, 1);

    // R9 priority register image
    wr_ctl(5'h0F); check("R9 erase wins", {27'h0, ctl_rdata}, 32'h03); idle(5);
    wr_ctl(5'h0D); check("R9 write wins", {27'h0, ctl_rdata}, 32'h05); idle(5);
    wr_ctl(5'h09); check("R9 fuse only", {27'h0, ctl_rdata}, 32'h09); idle(5);
    wr_ctl(5'h01); check("R9 fill only", {27'h0, ctl_rdata}, 32'h01); idle(5);

    // R8 fuse/lock reads
    for (int k = 0; k <= 4; k++) fuse_read(k, k[0]);
    for (int it = 0; it < 20; it++) begin
      fuse_bits = 8'($urandom); lock_bits = 8'($urandom);
      fuse_read($urandom_range(0, 4), 1'($urandom));
    end
    check_buf("R8 buffer untouched");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule